// File: doc/BRIEF.md
# Element-Size Byte Reordering Unit

This unit sits on the path between the operand/result buses and an execution unit whose arithmetic works in little-endian byte order. It takes a 64-bit word with two sideband fields. The first field is a 2-bit element-size code. The second is a data-endian mode flag. In big-endian mode it reverses the byte order inside every element of the chosen width. In little-endian mode it forwards the word untouched. Operands pass through one copy of the unit on their way into the ALU. Results pass through a second copy on their way back, so that the buses and latches always hold data in the current endian mode.

The sideband fields travel with each beat, so the size and the mode can change from one beat to the next. Input and output each use a valid/ready handshake. A parameter selects between a registered output stage and a purely combinational path. The registered stage is a two-state controller: `ST_EMPTY` holds no beat and `ST_FULL` holds one. From `ST_EMPTY`, an accepted beat moves to `ST_FULL` (load). In `ST_FULL`, a beat that leaves while a new one is accepted keeps the state (replace). A beat that leaves with nothing arriving moves back to `ST_EMPTY` (drain). A held beat that is not taken stays in `ST_FULL` (stall).

Top module: `endian_lane_swapper`

## Requirements
- R1: When `in_big_endian` is 0, `out_data` equals `in_data` for every size code.
- R2: When `in_big_endian` is 1 and `in_size` is 2'b00 (8-bit elements), `out_data` equals `in_data`.
- R3: When `in_big_endian` is 1 and `in_size` is 2'b01 (16-bit elements), output byte i (bits 8i+7..8i) is input byte i XOR 1.
- R4: When `in_big_endian` is 1 and `in_size` is 2'b10 (32-bit elements), output byte i is input byte i XOR 3.
- R5: When `in_big_endian` is 1 and `in_size` is 2'b11 (64-bit element), output byte i is input byte i XOR 7, which is a full reversal of the word.
- R6: Feeding an output word back in with the same size and mode returns the original word.
- R7: After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: `in_ready` is 0 while a held beat is stalled. Every accepted beat appears at the output exactly once and in order. With the registered stage, an accepted beat is presented on the cycle after acceptance.
- R9: Size and mode are taken from the beat they accompany, so changing them on consecutive beats gives each beat its own conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take the input beat |
| in_data | input | 64 | Word to reorder |
| in_size | input | 2 | Element width: 00=8, 01=16, 10=32, 11=64 bits |
| in_big_endian | input | 1 | 1 = big-endian mode (swap), 0 = little-endian (pass) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 64 | Reordered word |

## Verification
The overlap that matters is the replace transition. In that cycle the held beat leaves and a new beat, often with a different size and mode, is loaded. If either side of the handshake is lost, a beat is dropped or repeated. The bench creates this case by offering input every cycle while switching `out_ready` at random and alternating the mode and size on every beat. A queue of expected words, built from a lane-by-lane reversal written independently of the design, must then match the output stream word for word, and the count of words out must equal the count of words in.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

    typedef enum logic [1:0] {
        ELEM_B8  = 2'b00,
        ELEM_B16 = 2'b01,
        ELEM_B32 = 2'b10,
        ELEM_B64 = 2'b11
    } elem_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

    // Element width in bytes, clipped to the word width.
    function automatic int unsigned elem_bytes(elem_size_e sz, int unsigned word_bytes);
        int unsigned w;
        w = 32'd1 << sz;
        return (w > word_bytes) ? word_bytes : w;
    endfunction

endpackage

// File: rtl/lane_mask_decode.sv
module lane_mask_decode
    import bswap_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 8,
    localparam int unsigned IDX_W = $clog2(DATA_BYTES)
) (
    input  elem_size_e         size_code,
    input  logic               big_endian,
    output logic [IDX_W-1:0]   xor_mask
);

    logic [IDX_W-1:0] lane_span;

    always_comb begin
        lane_span = IDX_W'(elem_bytes(size_code, DATA_BYTES) - 1);
        xor_mask  = big_endian ? lane_span : '0;
    end

endmodule

// File: rtl/byte_xor_network.sv
module byte_xor_network #(
    parameter int unsigned DATA_BYTES = 8,
    localparam int unsigned IDX_W = $clog2(DATA_BYTES),
    localparam int unsigned WIDTH = DATA_BYTES * 8
) (
    input  logic [WIDTH-1:0]  word_in,
    input  logic [IDX_W-1:0]  xor_mask,
    output logic [WIDTH-1:0]  word_out
);

    logic [7:0] in_bytes [DATA_BYTES];

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_split
        assign in_bytes[b] = word_in[b*8 +: 8];
    end

    for (genvar o = 0; o < DATA_BYTES; o++) begin : g_lane
        logic [IDX_W-1:0] src_idx;
        assign src_idx = IDX_W'(o) ^ xor_mask;
        assign word_out[o*8 +: 8] = in_bytes[src_idx];
    end

endmodule

// File: rtl/hold_stage.sv
module hold_stage
    import bswap_pkg::*;
#(
    parameter int unsigned WIDTH   = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data
);

    if (REG_OUT) begin : g_reg
        stage_state_e     state_q, state_d;
        logic [WIDTH-1:0] data_q;
        logic             take;

        // state register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= ST_EMPTY;
            end else begin
                state_q <= state_d;
            end
        end

        // next state and handshake outputs
        always_comb begin
            state_d  = state_q;
            up_ready = 1'b0;
            dn_valid = 1'b0;
            unique case (state_q)
                ST_EMPTY: begin
                    up_ready = 1'b1;
                    if (up_valid) begin
                        state_d = ST_FULL;          // load
                    end
                end
                ST_FULL: begin
                    dn_valid = 1'b1;
                    up_ready = dn_ready;
                    if (dn_ready && !up_valid) begin
                        state_d = ST_EMPTY;         // drain
                    end                             // else replace or stall
                end
                default: state_d = ST_EMPTY;
            endcase
        end

        assign take = up_valid && up_ready;

        always_ff @(posedge clk) begin
            if (take) begin
                data_q <= up_data;
            end
        end

        assign dn_data = data_q;
    end else begin : g_pass
        assign dn_valid = up_valid;
        assign up_ready = dn_ready;
        assign dn_data  = up_data;
    end

endmodule

// File: rtl/endian_lane_swapper.sv
module endian_lane_swapper
    import bswap_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 8,
    parameter bit          REG_OUT    = 1'b1,
    localparam int unsigned WIDTH = DATA_BYTES * 8,
    localparam int unsigned IDX_W = $clog2(DATA_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      in_data,
    input  logic [1:0]       in_size,
    input  logic             in_big_endian,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_data
);

    logic [IDX_W-1:0] lane_mask;
    logic [WIDTH-1:0] swapped;
    logic [WIDTH-1:0] word_in;
    logic [WIDTH-1:0] word_out;

    assign word_in  = WIDTH'(in_data);
    assign out_data = 64'(word_out);

    lane_mask_decode #(.DATA_BYTES(DATA_BYTES)) u_decode (
        .size_code  (elem_size_e'(in_size)),
        .big_endian (in_big_endian),
        .xor_mask   (lane_mask)
    );

    byte_xor_network #(.DATA_BYTES(DATA_BYTES)) u_net (
        .word_in  (word_in),
        .xor_mask (lane_mask),
        .word_out (swapped)
    );

    hold_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (swapped),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (word_out)
    );

endmodule

// File: rtl/endian_lane_swapper_checker.sv
module endian_lane_swapper_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [63:0] in_data,
    input logic [1:0]  in_size,
    input logic        in_big_endian,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data
);

    logic [63:0] reversed_in;
    for (genvar k = 0; k < 8; k++) begin : g_rev
        assign reversed_in[k*8 +: 8] = in_data[(7-k)*8 +: 8];
    end

    if (REG_OUT) begin : g_reg_props
        assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

        assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |-> !in_ready);

        assert_accept_presents_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> out_valid);

        assert_little_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && !in_big_endian) |=> (out_data == $past(in_data)));

        assert_full_reverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready && in_big_endian && in_size == 2'b11)
                |=> (out_data == $past(reversed_in)));
    end

endmodule

bind endian_lane_swapper endian_lane_swapper_checker #(.REG_OUT(REG_OUT)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_size       (in_size),
    .in_big_endian (in_big_endian),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data)
);

// File: tb/endian_lane_swapper_test.sv
`timescale 1ns/1ps
module endian_lane_swapper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [1:0]  in_size = '0;
    logic        in_big_endian = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    endian_lane_swapper uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_size(in_size), .in_big_endian(in_big_endian),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Reference: reverse the bytes of each element, element by element.
    function automatic logic [63:0] ref_conv(logic [63:0] d, logic [1:0] sz, logic be);
        logic [63:0] r;
        int n;
        r = d;
        if (be) begin
            n = 1 << sz;
            for (int e = 0; e < 8 / n; e++)
                for (int k = 0; k < n; k++)
                    r[(e*n + k)*8 +: 8] = d[(e*n + (n-1-k))*8 +: 8];
        end
        return r;
    endfunction

    function automatic string req_of(logic [1:0] sz, logic be);
        if (!be) return "R1";
        case (sz)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [63:0] exp_q[$];
    string       tag_q[$];

    // Stream n beats; mode 0: sweep sizes/modes, mode 1: alternate per beat (R9).
    task automatic run_stream(int n, int pattern, int ready_pct, string force_tag);
        int issued = 0;
        int got = 0;
        bit pending = 1'b0;
        logic [63:0] e;
        string t;
        exp_q.delete();
        tag_q.delete();
        while (got < n) begin
            @(negedge clk);
            if (issued < n) begin
                if (!pending) begin
                    in_data = {$urandom, $urandom};
                    if (issued % 5 == 0) in_data = 64'h0706050403020100;
                    if (pattern == 0) begin
                        in_size = 2'(issued % 4);
                        in_big_endian = ((issued / 4) % 2) == 1;
                    end else begin
                        in_size = 2'($urandom % 4);
                        in_big_endian = issued[0];
                    end
                end
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            out_ready = ($urandom % 100) < ready_pct;
            #1;
            if (out_valid && out_ready) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, t, out_data, e);
                got++;
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(ref_conv(in_data, in_size, in_big_endian));
                tag_q.push_back(force_tag != "" ? force_tag : req_of(in_size, in_big_endian));
                issued++;
                pending = 1'b0;
            end else begin
                pending = in_valid;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        #1;
        check(exp_q.size() == 0 && !out_valid, "R8", 64'(exp_q.size()), 64'd0);
    endtask

    // Send one beat and return the converted word.
    task automatic one_beat(logic [63:0] d, logic [1:0] sz, logic be, output logic [63:0] r);
        @(negedge clk);
        in_data = d; in_size = sz; in_big_endian = be; in_valid = 1'b1; out_ready = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        while (!out_valid) begin @(negedge clk); #1; end
        r = out_data;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] a, b, d0, d1, held;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R7", 64'(out_valid), 64'd0);
        check(in_ready, "R7", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready, "R7", {62'd0, out_valid, in_ready}, 64'd1);

        // R1..R5 sweep, full throughput then with back-pressure
        run_stream(64, 0, 100, "");
        run_stream(96, 0, 50, "");
        // R9: mode flips every beat, replace transitions under random ready
        run_stream(200, 1, 60, "R9");

        // R6 round trip for all sizes and modes
        for (int sz = 0; sz < 4; sz++) begin
            for (int be = 0; be < 2; be++) begin
                d0 = {$urandom, $urandom};
                one_beat(d0, 2'(sz), be[0], a);
                one_beat(a, 2'(sz), be[0], b);
                check(b == d0, "R6", b, d0);
            end
        end

        // R7/R8 stall: load two beats, hold ready low
        d0 = 64'h1122334455667788;
        d1 = 64'hA1B2C3D4E5F60718;
        @(negedge clk);
        out_ready = 1'b0;
        in_data = d0; in_size = 2'b10; in_big_endian = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_data = d1; in_size = 2'b01;
        #1;
        held = out_data;
        check(held == ref_conv(d0, 2'b10, 1'b1), "R4", held, ref_conv(d0, 2'b10, 1'b1));
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1;
            check(out_valid && out_data == held, "R7", out_data, held);
            check(!in_ready, "R8", 64'(in_ready), 64'd0);
        end
        out_ready = 1'b1;
        #1;
        check(in_ready, "R8", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid && out_data == ref_conv(d1, 2'b01, 1'b1), "R8",
              out_data, ref_conv(d1, 2'b01, 1'b1));
        @(negedge clk);
        #1;
        check(!out_valid, "R8", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule